// File: doc/BRIEF.md
# Multi-Channel PWM DAC Bank

This block holds fourteen independent 8-bit pulse-width modulators. Their outputs are filtered off-chip into slow analog control voltages, such as monitor adjustment levels. All channels share one 8-bit period counter. The counter advances on a fast tick enable, nominally 16 MHz, so a period is 256 steps of 62.5 ns and lasts 16 µs. A channel output is high while the counter is below the channel's duty code, so the high portion starts each period and lasts N steps.

Software sets each channel through a small register bus. Every channel has one 8-bit duty register, and these sit at consecutive addresses starting from zero. A written value is first held in the register. At the next period wrap it is copied into a working copy that the comparator uses, so a period never contains a runt pulse. The first eight channels drive open-drain pads: the block gives them a pull-low enable and never a high drive. The remaining six channels drive push-pull pads with the PWM level itself.

Top module: `pwm_dac_bank`

## Requirements
- R1: After reset, every duty register reads 80h and every channel produces 128 high steps per period.
- R2: A write with `regWe` high to an address 0..13 stores `regWdata` in that channel's register. `regRdata` shows the addressed register combinationally.
- R3: Addresses 14 and 15 read as 00h, and a write to them changes no duty register.
- R4: The period counter advances by one in each clock cycle where `tickEn` is high. It holds in all other cycles. One period is 256 ticks, with the counter running 0 up to 255.
- R5: With a working duty N, a channel's level is high exactly while the counter is below N. The level is therefore high for N ticks starting at counter value 0, and it is always low at counter value 255.
- R6: A duty code of 00h keeps the channel's level low for the whole period.
- R7: A register write takes effect only at the tick where the counter wraps from 255 to 0. The period already running keeps the previous value.
- R8: For channels 0..7, `odPullLow[i]` is high exactly when the channel's level is low.
- R9: For channels 8..13, `ppLevel[i-8]` equals the channel's level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Step enable for the period counter |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 4 | Register address (channel index) |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data for `regAddr` |
| odPullLow | output | 8 | Pull-low enables, open-drain channels 0..7 |
| ppLevel | output | 6 | Drive levels, push-pull channels 8..13 |

## Verification
A wrong counter value moves the high window of every channel at once. It shows on the outputs within one period, because the edge falls at the wrong step. A working copy loaded at the wrong time leaks a new duty into the period that is already running, or delays it by a whole period. Both show up as a wrong high count in the first period after a write. A corrupted duty register shows up at once on a read-back, and from the next wrap onward on the pin.

// File: rtl/pwm_dac_pkg.sv
package pwm_dac_pkg;
  // strobes from the control unit to the datapath
  typedef struct packed {
    logic advance; // step the period counter
    logic reload;  // copy duty registers into working copies
  } pwmStrobe_t;
endpackage

// File: rtl/pwm_dac_ctrl.sv
module pwm_dac_ctrl
  import pwm_dac_pkg::*;
(
  input  logic       tickEn,
  input  logic       atLast,
  output pwmStrobe_t strobe
);
  always_comb begin
    strobe.advance = tickEn;
    // the wrap tick doubles as the update point
    strobe.reload  = tickEn && atLast;
  end
endmodule

// File: rtl/pwm_dac_regs.sv
module pwm_dac_regs #(
  parameter int NUM_CH = 14,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4,
  parameter logic [DATA_W-1:0] RESET_VAL = 8'h80
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     regWe,
  input  logic [ADDR_W-1:0]        regAddr,
  input  logic [DATA_W-1:0]        regWdata,
  output logic [DATA_W-1:0]        regRdata,
  output logic [NUM_CH*DATA_W-1:0] dutyFlat
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_reg
    logic hit;
    assign hit = regWe && (regAddr == ADDR_W'(i));
    always_ff @(posedge clk) begin
      if (!rstN)    dutyFlat[i*DATA_W +: DATA_W] <= RESET_VAL;
      else if (hit) dutyFlat[i*DATA_W +: DATA_W] <= regWdata;
    end
  end

  always_comb begin
    regRdata = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (regAddr == ADDR_W'(i)) regRdata = dutyFlat[i*DATA_W +: DATA_W];
    end
  end
endmodule

// File: rtl/pwm_dac_datapath.sv
module pwm_dac_datapath
  import pwm_dac_pkg::*;
#(
  parameter int NUM_CH = 14,
  parameter int OD_CH  = 8,
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] RESET_VAL = 8'h80,
  localparam int PP_CH = NUM_CH - OD_CH
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  pwmStrobe_t               strobe,
  input  logic [NUM_CH*DATA_W-1:0] dutyFlat,
  output logic                     atLast,
  output logic [DATA_W-1:0]        cnt,
  output logic [NUM_CH*DATA_W-1:0] shadowFlat,
  output logic [NUM_CH-1:0]        levelVec,
  output logic [OD_CH-1:0]         odPullLow,
  output logic [PP_CH-1:0]         ppLevel
);
  always_ff @(posedge clk) begin
    if (!rstN)               cnt <= '0;
    else if (strobe.advance) cnt <= cnt + DATA_W'(1);
  end

  assign atLast = (cnt == {DATA_W{1'b1}});

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rstN)              shadowFlat[i*DATA_W +: DATA_W] <= RESET_VAL;
      else if (strobe.reload) shadowFlat[i*DATA_W +: DATA_W] <= dutyFlat[i*DATA_W +: DATA_W];
    end
    // high while count below duty; a zero duty never goes high
    assign levelVec[i] = (cnt < shadowFlat[i*DATA_W +: DATA_W]);
  end

  assign odPullLow = ~levelVec[OD_CH-1:0];
  assign ppLevel   = levelVec[NUM_CH-1:OD_CH];
endmodule

// File: rtl/pwm_dac_bank.sv
module pwm_dac_bank
  import pwm_dac_pkg::*;
#(
  parameter int NUM_CH = 14,
  parameter int OD_CH  = 8,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4,
  parameter logic [DATA_W-1:0] RESET_DUTY = 8'h80
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      tickEn,
  input  logic                      regWe,
  input  logic [ADDR_W-1:0]         regAddr,
  input  logic [DATA_W-1:0]         regWdata,
  output logic [DATA_W-1:0]         regRdata,
  output logic [OD_CH-1:0]          odPullLow,
  output logic [NUM_CH-OD_CH-1:0]   ppLevel
);
  pwmStrobe_t               strobe;
  logic                     atLast;
  logic [DATA_W-1:0]        cnt;
  logic [NUM_CH*DATA_W-1:0] dutyFlat;
  logic [NUM_CH*DATA_W-1:0] shadowFlat;
  logic [NUM_CH-1:0]        levelVec;

  pwm_dac_ctrl u_ctrl (
    .tickEn (tickEn),
    .atLast (atLast),
    .strobe (strobe)
  );

  pwm_dac_regs #(
    .NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .RESET_VAL(RESET_DUTY)
  ) u_regs (
    .clk      (clk),
    .rstN     (rstN),
    .regWe    (regWe),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .regRdata (regRdata),
    .dutyFlat (dutyFlat)
  );

  pwm_dac_datapath #(
    .NUM_CH(NUM_CH), .OD_CH(OD_CH), .DATA_W(DATA_W), .RESET_VAL(RESET_DUTY)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .dutyFlat   (dutyFlat),
    .atLast     (atLast),
    .cnt        (cnt),
    .shadowFlat (shadowFlat),
    .levelVec   (levelVec),
    .odPullLow  (odPullLow),
    .ppLevel    (ppLevel)
  );
endmodule

// File: rtl/pwm_dac_bank_chk.sv
module pwm_dac_bank_chk #(
  parameter int NUM_CH = 14,
  parameter int DATA_W = 8
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     tickEn,
  input logic [DATA_W-1:0]        cnt,
  input logic [NUM_CH*DATA_W-1:0] shadowFlat,
  input logic [NUM_CH-1:0]        levelVec
);
  // R4
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !tickEn |=> $stable(cnt));

  // R4
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    tickEn |=> cnt == $past(cnt) + DATA_W'(1));

  // R7
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(tickEn && cnt == {DATA_W{1'b1}}) |=> $stable(shadowFlat));

  // R5
  last_step_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    cnt == {DATA_W{1'b1}} |-> levelVec == '0);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    // R6
    zero_duty_low_chk: assert property (@(posedge clk) disable iff (!rstN)
      shadowFlat[i*DATA_W +: DATA_W] == '0 |-> !levelVec[i]);

    // R5
    first_step_chk: assert property (@(posedge clk) disable iff (!rstN)
      (cnt == '0 && shadowFlat[i*DATA_W +: DATA_W] != '0) |-> levelVec[i]);
  end
endmodule

bind pwm_dac_bank pwm_dac_bank_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .tickEn     (tickEn),
  .cnt        (cnt),
  .shadowFlat (shadowFlat),
  .levelVec   (levelVec)
);

// File: tb/tb_pwm_dac_bank.sv
module tb_pwm_dac_bank;
  localparam int NCH = 14;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b0;
  logic       regWe = 1'b0;
  logic [3:0] regAddr = '0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic [7:0] odPullLow;
  logic [5:0] ppLevel;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  pwm_dac_bank dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .regWe(regWe),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .odPullLow(odPullLow), .ppLevel(ppLevel)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic lvlOf(input int ch);
    if (ch < 8) return ~odPullLow[ch];
    return ppLevel[ch-8];
  endfunction

  task automatic wr(input int a, input int d);
    @(negedge clk);
    regWe = 1'b1; regAddr = 4'(a); regWdata = 8'(d);
    @(posedge clk); #1;
    regWe = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    regAddr = 4'(a);
    #1 d = int'(regRdata);
  endtask

  // one full period from counter 0; gap = idle cycles between ticks
  task automatic measure(input logic [7:0] expv [NCH], input int gap, input string req);
    int hi [NCH];
    int mism [NCH];
    for (int c = 0; c < NCH; c++) begin hi[c] = 0; mism[c] = 0; end
    for (int ph = 0; ph < 256; ph++) begin
      @(negedge clk);
      for (int c = 0; c < NCH; c++) begin
        logic l;
        l = lvlOf(c);
        if (l) hi[c]++;
        if (l !== (ph < int'(expv[c]))) mism[c]++;
      end
      tickEn = 1'b1;
      @(posedge clk); #1;
      tickEn = 1'b0;
      repeat (gap) @(posedge clk);
    end
    for (int c = 0; c < NCH; c++) begin
      chk({req, " high count"}, hi[c], int'(expv[c]));
      chk({req, " window shape"}, mism[c], 0);
    end
  endtask

  logic [7:0] allMid [NCH];
  logic [7:0] patA [NCH];
  logic [7:0] patB [NCH];

  task automatic t_reset();
    int d;
    for (int c = 0; c < NCH; c++) begin
      rd(c, d);
      chk("R1 reset read", d, 8'h80);
    end
    measure(allMid, 0, "R1/R5/R8/R9 reset period");
  endtask

  task automatic t_access();
    int d;
    for (int c = 0; c < NCH; c++) wr(c, int'(patA[c]));
    for (int c = 0; c < NCH; c++) begin
      rd(c, d);
      chk("R2 readback", d, int'(patA[c]));
    end
    wr(14, 8'h55);
    wr(15, 8'hAA);
    rd(14, d); chk("R3 read addr 14", d, 0);
    rd(15, d); chk("R3 read addr 15", d, 0);
    for (int c = 0; c < NCH; c++) begin
      rd(c, d);
      chk("R3 no side effect", d, int'(patA[c]));
    end
  endtask

  task automatic t_update();
    // writes landed mid-cycle at counter 0: this period keeps 80h
    measure(allMid, 0, "R7 old value kept");
    measure(patA, 0, "R5/R6/R8/R9 new duty");
    for (int c = 0; c < NCH; c++) wr(c, int'(patB[c]));
    measure(patA, 0, "R7 write waits for wrap");
    measure(patB, 0, "R7 applied after wrap");
  endtask

  task automatic t_gated();
    logic [7:0] snapOd;
    logic [5:0] snapPp;
    // idle cycles between ticks must not change the pattern
    measure(patB, 3, "R4 gated ticks");
    // park at counter 0 for a while; outputs must hold
    @(negedge clk);
    snapOd = odPullLow; snapPp = ppLevel;
    repeat (40) @(posedge clk);
    @(negedge clk);
    chk("R4 hold od", int'(odPullLow), int'(snapOd));
    chk("R4 hold pp", int'(ppLevel), int'(snapPp));
    measure(patB, 0, "R4 resume");
  endtask

  initial begin
    for (int c = 0; c < NCH; c++) allMid[c] = 8'h80;
    patA = '{8'h01, 8'hFF, 8'h00, 8'h02, 8'h7F, 8'h40, 8'hC3, 8'h10,
             8'h01, 8'hFF, 8'h00, 8'h80, 8'h3C, 8'hE7};
    patB = '{8'hFE, 8'h00, 8'h81, 8'h05, 8'h00, 8'hFF, 8'h01, 8'h99,
             8'h00, 8'h02, 8'hFF, 8'h11, 8'h01, 8'h7E};
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    t_reset();
    t_access();
    t_update();
    t_gated();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule